// File: doc/BRIEF.md
# Serial Transmit Path with Selectable Character Buffer

This block turns bytes written by a host into asynchronous serial frames on a single output line. A frame is a low start bit, then 5 to 8 data bits with bit 0 first, then an optional parity bit, then one or two high stop bits. Every bit lasts exactly sixteen pulses of a 16x oversampling enable. Divisor generation is outside the block: it only consumes the enable pulse.

A mode input sets how much the host may queue. With the mode low, the block holds a single character. With the mode high, it holds a first-in first-out store of `DEPTH` characters. In both modes one further character may be in flight in the shift stage.

Two status flags are kept apart. The holding flag reports that the host-side storage is empty. The line flag reports that the storage and the shift stage are both empty. A pending transmit-empty event is latched when the last stored byte leaves for the shift stage. That event drives an interrupt request, gated by an enable input.

Top module: `serial_tx_path`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `line_empty` is 1 and `irq` is 0.
- R2: The line idles at 1. A frame begins with a 0 start bit and ends with stop bits of 1. Every bit of a frame is held for exactly 16 pulses of `tick16`, counted from the cycle after the byte enters the shift stage.
- R3: `wlen` selects the word length, from 0 = 5 bits up to 3 = 8 bits. Data bits go out with bit 0 first, and data bits above the word length are not sent. `two_stop` = 1 gives two stop bits; 0 gives one.
- R4: With `par_en` = 1, one parity bit follows the data bits. With `par_even` = 1 the sent data bits plus the parity bit hold an even number of ones; with 0 they hold an odd number.
- R5: With `fifo_on` = 0 the block stores one character. An accepted write clears `hold_empty`. `hold_empty` sets again in the next cycle if the shift stage is idle, because the byte then moves into it. A write while a character is already stored is discarded.
- R6: With `fifo_on` = 1, up to `DEPTH` characters are stored and sent in write order. `hold_empty` is 1 exactly when none is stored.
- R7: A write when the storage is full is discarded and leaves the stored characters unchanged.
- R8: `line_empty` is 1 only when the storage is empty and the shift stage is idle.
- R9: An event is latched when a byte moving to the shift stage leaves the storage empty. `irq` equals that latched event AND `irq_en`. The event is cleared by `isr_rd` or by an accepted write. If an event and `isr_rd` fall in the same cycle, the event wins.
- R10: In the cycle where `fifo_on` changes, the storage is emptied, a write in that cycle is discarded, and no event is raised. A character already in the shift stage is still sent completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x oversampling enable pulse |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| fifo_on | input | 1 | 1 selects the multi-entry store, 0 selects single-character mode |
| wlen | input | 2 | Word length, 0..3 meaning 5..8 bits |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop | input | 1 | 1 = two stop bits |
| irq_en | input | 1 | Enable for the transmit-empty interrupt |
| isr_rd | input | 1 | Host read of interrupt status, clears the pending event |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Host-side storage holds no character |
| line_empty | output | 1 | Storage and shift stage are both empty |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
Two cases can land in the same cycle, and the bench drives each one deliberately. In the first, the shift stage pulls the last stored byte in the same cycle as the host's status read. The bench writes one byte while the enable is held off, which stalls the shift stage, and raises `isr_rd` in exactly the cycle of the transfer; the request must remain set afterwards. In the second, a mode switch coincides with a write. The bench toggles `fifo_on` and strobes `wr_en` together, then checks that `hold_empty` stays set, that no interrupt is raised, and that only the character already in the shift stage appears on the line.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int BYTE_W        = 8;
  localparam int TICKS_PER_BIT = 16;
  localparam int TICK_W        = $clog2(TICKS_PER_BIT);
  // start + data + parity + two stop bits
  localparam int FRAME_W       = 1 + BYTE_W + 1 + 2;
  localparam int BITS_W        = $clog2(FRAME_W + 1);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/stx_store.sv
module stx_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  byte_t      data,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  output logic       busy,
  output logic       txd
);
  logic [FRAME_W-1:0] frame, frame_q;
  logic [BITS_W-1:0]  nbits, bcnt;
  logic [TICK_W-1:0]  tcnt;
  logic [FRAME_W-1:0] data_ext;
  byte_t              mask;
  logic               pbit;
  int                 wl;

  always_comb begin
    wl       = 5 + int'(wlen);
    mask     = byte_t'(8'hFF >> (2'd3 - wlen));
    pbit     = par_even ? ^(data & mask) : ~^(data & mask);
    data_ext = FRAME_W'(data);
    for (int k = 0; k < FRAME_W; k++) begin
      if (k == 0)                  frame[k] = 1'b0;
      else if (k <= wl)            frame[k] = data_ext[k-1];
      else if (par_en && k == wl+1) frame[k] = pbit;
      else                         frame[k] = 1'b1;
    end
    nbits = BITS_W'(1 + wl + int'(par_en) + (two_stop ? 2 : 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '1;
      busy    <= 1'b0;
      tcnt    <= '0;
      bcnt    <= '0;
    end else if (load) begin
      frame_q <= frame;
      busy    <= 1'b1;
      tcnt    <= '0;
      bcnt    <= nbits - 1'b1;
    end else if (busy && tick) begin
      if (tcnt == TICK_W'(TICKS_PER_BIT - 1)) begin
        tcnt    <= '0;
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        if (bcnt == '0) busy <= 1'b0;
        else            bcnt <= bcnt - 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd = frame_q[0];
endmodule

// File: rtl/serial_tx_path.sv
module serial_tx_path
  import stx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_on,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic       irq_en,
  input  logic       isr_rd,
  output logic       txd,
  output logic       hold_empty,
  output logic       line_empty,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] cnt, cap;
  logic          mode_q, chg, push, pop, busy, pend;
  byte_t         head;

  always_ff @(posedge clk) mode_q <= fifo_on;

  always_comb begin
    chg  = !rst && (fifo_on != mode_q);
    cap  = fifo_on ? CW'(DEPTH) : CW'(1);
    push = wr_en && !chg && (cnt < cap);
    pop  = !busy && (cnt != '0) && !chg;
  end

  stx_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .flush(chg), .push(push), .pop(pop),
    .wdata(wr_data), .rdata(head), .count(cnt)
  );

  stx_shifter u_shift (
    .clk(clk), .rst(rst), .tick(tick16), .load(pop), .data(head),
    .wlen(wlen), .par_en(par_en), .par_even(par_even),
    .two_stop(two_stop), .busy(busy), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (rst)                                pend <= 1'b0;
    else if (pop && cnt == CW'(1) && !push) pend <= 1'b1;
    else if (isr_rd || push)                pend <= 1'b0;
  end

  assign hold_empty = (cnt == '0);
  assign line_empty = (cnt == '0) && !busy;
  assign irq        = pend && irq_en;
endmodule

// File: rtl/serial_tx_path_chk.sv
module serial_tx_path_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic fifo_on,
  input logic irq_en,
  input logic isr_rd,
  input logic txd,
  input logic hold_empty,
  input logic line_empty,
  input logic irq
);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);
  // R8
  line_idle_chk: assert property (@(posedge clk) disable iff (rst)
    line_empty |-> (hold_empty && txd));
  // R5
  write_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hold_empty && $stable(fifo_on)) |=> !hold_empty);
  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (isr_rd && hold_empty) |=> !irq);
  // R10
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_on != $past(fifo_on)) |=> hold_empty);
endmodule

bind serial_tx_path serial_tx_path_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .fifo_on(fifo_on),
  .irq_en(irq_en), .isr_rd(isr_rd), .txd(txd),
  .hold_empty(hold_empty), .line_empty(line_empty), .irq(irq)
);

// File: tb/serial_tx_path_bench.sv
`timescale 1ns/1ps
module serial_tx_path_bench;
  logic       clk = 1'b0, rst = 1'b1, tick16 = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fifo_on = 1'b0, par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic       irq_en = 1'b0, isr_rd = 1'b0;
  logic       txd, hold_empty, line_empty, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_tx_path u_serial_tx_path (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_on(fifo_on), .wlen(wlen), .par_en(par_en), .par_even(par_even),
    .two_stop(two_stop), .irq_en(irq_en), .isr_rd(isr_rd), .txd(txd),
    .hold_empty(hold_empty), .line_empty(line_empty), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic exp_bit(input int j, input logic [7:0] d);
    int wl = 5 + int'(wlen);
    int ones = 0;
    for (int i = 0; i < wl; i++) ones += int'(d[i]);
    if (j == 0) return 1'b0;
    if (j <= wl) return d[j-1];
    if (par_en && j == wl + 1) return par_even ? logic'(ones % 2) : logic'(1 - ones % 2);
    return 1'b1;
  endfunction

  // R2 R3 R4: each bit compared on all 16 samples; tick16 held high
  task automatic expect_frame(input logic [7:0] d, input string req);
    int nb = 1 + 5 + int'(wlen) + int'(par_en) + (two_stop ? 2 : 1);
    int miss = 0, guard = 0;
    tick16 = 1'b1;
    while (txd !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
    for (int j = 0; j < nb; j++)
      for (int s = 0; s < 16; s++) begin
        if (txd !== exp_bit(j, d)) miss++;
        @(negedge clk);
      end
    check(miss == 0 && guard < 400, req, miss, 0);
  endtask

  task automatic quiet_line(input int n, input string req);
    int hi = 0;
    tick16 = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (txd === 1'b1 && line_empty === 1'b1) hi++;
      @(negedge clk);
    end
    check(hi == n, req, hi, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check(txd === 1 && hold_empty === 1 && line_empty === 1 && irq === 0,
          "R1 reset state", {txd, hold_empty, line_empty, irq}, 4'b1110);

    // R5 timing of holding flag in single mode
    tick16 = 1'b1;
    wr(8'h5A);
    check(hold_empty === 0, "R5 hold after write", hold_empty, 0);
    @(negedge clk);
    check(hold_empty === 1 && line_empty === 0, "R5 R8 moved to shifter",
          {hold_empty, line_empty}, 2'b10);
    expect_frame(8'h5A, "R2 8N1 frame");
    check(line_empty === 1, "R8 idle after frame", line_empty, 1);

    // R2 R3 R4 sweep of every format with two data patterns
    for (int cfg = 0; cfg < 32; cfg++)
      for (int p = 0; p < 2; p++) begin
        logic [7:0] d = 8'hA5 ^ 8'(cfg * 37 + p * 91);
        @(negedge clk);
        wlen = cfg[1:0]; par_en = cfg[2]; par_even = cfg[3]; two_stop = cfg[4];
        wr(d);
        expect_frame(d, "R3 R4 format sweep");
        check(line_empty === 1, "R8 empty after sweep frame", line_empty, 1);
      end

    // R5 R7 single mode: third write discarded
    @(negedge clk); wlen = 2'd3; par_en = 0; two_stop = 0; tick16 = 0;
    wr(8'h11); wr(8'h22); wr(8'h33);
    check(hold_empty === 0, "R5 one stored", hold_empty, 0);
    expect_frame(8'h11, "R5 first char");
    expect_frame(8'h22, "R5 second char");
    quiet_line(250, "R5 R7 extra write dropped");

    // R6 R7 multi-entry mode, 18 writes while stalled
    @(negedge clk); tick16 = 0; fifo_on = 1; irq_en = 1;
    @(negedge clk);
    for (int k = 0; k < 18; k++) begin
      wr_en = 1; wr_data = 8'(8'h3C + k * 29);
      @(negedge clk);
    end
    wr_en = 0;
    check(hold_empty === 0 && irq === 0, "R6 storage filled", {hold_empty, irq}, 0);
    for (int k = 0; k < 17; k++) expect_frame(8'(8'h3C + k * 29), "R6 R7 order");
    quiet_line(200, "R7 overflow byte absent");
    check(irq === 1 && hold_empty === 1, "R9 drained raises irq", {irq, hold_empty}, 2'b11);
    @(negedge clk); isr_rd = 1;
    @(negedge clk); isr_rd = 0;
    check(irq === 0, "R9 status read clears", irq, 0);

    // R9 event and status read in the same cycle
    tick16 = 0;
    @(negedge clk); wr_en = 1; wr_data = 8'hC3;
    @(negedge clk); wr_en = 0; isr_rd = 1;
    @(negedge clk); isr_rd = 0;
    check(irq === 1 && hold_empty === 1 && line_empty === 0,
          "R9 R8 set wins over read", {irq, hold_empty, line_empty}, 3'b110);
    irq_en = 0;
    @(negedge clk);
    check(irq === 0, "R9 gated off", irq, 0);
    irq_en = 1;
    @(negedge clk);
    check(irq === 1, "R9 latched while gated", irq, 1);
    isr_rd = 1;
    @(negedge clk); isr_rd = 0;
    expect_frame(8'hC3, "R9 char sent");

    // R9 accepted write clears the event
    tick16 = 0;
    wr(8'h96);
    @(negedge clk);
    check(irq === 1, "R9 event on transfer", irq, 1);
    wr(8'h69);
    check(irq === 0 && hold_empty === 0, "R9 write clears", {irq, hold_empty}, 2'b00);
    wr(8'hF0);

    // R10 mode switch together with a write
    @(negedge clk); fifo_on = 0; wr_en = 1; wr_data = 8'h0F;
    @(negedge clk); wr_en = 0;
    check(hold_empty === 1 && irq === 0 && line_empty === 0, "R10 flush",
          {hold_empty, irq, line_empty}, 3'b100);
    expect_frame(8'h96, "R10 in-flight char completes");
    quiet_line(250, "R10 flushed chars absent");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule